// File: doc/BRIEF.md
# Hardware Standby Power Sequencer

This block watches two active-low device pins, a standby request and a reset request, and walks the device through its power states: standby with the oscillator stopped, reset with the oscillator settling, reset with a settled oscillator, a short exception-handling phase, and normal execution. It drives the oscillator enable and the run enable, reports the current state as a 3-bit code, and emits a single-cycle pulse when exception handling starts.

The order in which the two pins move decides what happens. Standby is taken only when the standby request falls while reset is already held. Raising the standby request restarts the oscillator and starts a counted settling period, measured in cycles of a free-running reference clock. Reset must stay asserted until that period has elapsed. An early release raises a sticky violation flag, and the sequencer still waits out the full period. After power-on, standby requests are ignored until reset has been held for a minimum time with standby high and has then been released.

Both pins pass through two-flop synchronizers. The active-low power-on input clears the whole block asynchronously.

Top module: `hw_standby_seq`

## Requirements
- R1: A change on either pin first changes `stateCode` at the third rising clock edge after the pin change, because of the two synchronizer flops and the state register.
- R2: While `porN` is low, the state is 1 (reset, oscillator settling), `oscEnable` is 1, and `settleDone`, `excStart`, `runEnable` and `seqViolation` are 0.
- R3: The settling state (code 1) lasts exactly `SettleCycles` cycles. Its counter restarts on every entry. `settleDone` goes high in the same cycle that the state becomes 2 (reset, settled).
- R4: In state 2, a high reset pin moves the state to 3 (exception handling). `excStart` is high only in the first cycle of state 3. State 3 lasts `ExcCycles` cycles, then the state becomes 4 (run) with `runEnable` high.
- R5: Once armed, a low standby pin while the reset pin is low forces state 0 (standby) from any state. In state 0, `oscEnable`, `runEnable` and `settleDone` are all 0.
- R6: A low standby pin while the reset pin is high changes neither the state nor any output.
- R7: In state 0, a high standby pin moves the state to 1 and restarts the settling count.
- R8: If the synchronized reset pin is high during any cycle of state 1, `seqViolation` is set. It stays set until the next entry into state 0. The full settling period is still served before the state moves on.
- R9: A low reset pin in state 3 or 4 returns the state to 2 with `settleDone` kept high and no new settling period.
- R10: After power-on, standby is blocked until the reset pin has been seen low for at least `PorHoldCycles` consecutive cycles with the standby pin high, and has then been released. Whenever the standby pin is low, the hold count restarts.
- R11: State codes are: 0 standby, 1 reset with oscillator settling, 2 reset with oscillator settled, 3 exception handling, 4 run. No other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| porN | input | 1 | Power-on indication, active low, asynchronous clear |
| standbyInN | input | 1 | Standby request pin, active low, asynchronous |
| resetInN | input | 1 | Reset request pin, active low, asynchronous |
| oscEnable | output | 1 | Oscillator enable, low only in standby |
| settleDone | output | 1 | Oscillator settling period has elapsed |
| stateCode | output | 3 | Current power state (see R11) |
| excStart | output | 1 | One-cycle pulse at the start of exception handling |
| runEnable | output | 1 | High in the run state |
| seqViolation | output | 1 | Sticky flag: reset was released before settling finished |

## Verification
Two functions can act in the same cycle: the end of the settling count, and the early-release check on the synchronized reset pin. The bench sweeps the reset release across the settling boundary, one cycle at a time, and compares the violation flag against arithmetic on the release offset. A release that reaches the state logic in the last settling cycle must flag a violation. A release that reaches it one cycle later must not. In both cases the run state must still be reached.

// File: rtl/hw_standby_seq_pkg.sv
package hw_standby_seq_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY      = 3'd0,
    ST_RESET_OSC    = 3'd1,
    ST_RESET_STABLE = 3'd2,
    ST_EXC          = 3'd3,
    ST_RUN          = 3'd4
  } pwrState_t;

  // Strobes from the control FSM to the counting datapath.
  typedef struct packed {
    logic settleClr;
    logic settleCount;
    logic excClr;
    logic excCount;
  } seqStrobe_t;

endpackage

// File: rtl/hw_standby_pin_sync.sv
module hw_standby_pin_sync #(
  parameter int Width = 2,
  parameter int Stages = 2,
  parameter logic [Width-1:0] ResetVal = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);

  logic [Width-1:0] stage [Stages];

  genvar g;
  generate
    for (g = 0; g < Stages; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= ResetVal;
          else       stage[g] <= din;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= ResetVal;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[Stages-1];

endmodule

// File: rtl/hw_standby_datapath.sv
module hw_standby_datapath
  import hw_standby_seq_pkg::*;
#(
  parameter int SettleCycles = 8192,
  parameter int ExcCycles = 4,
  parameter int PorHoldCycles = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       standbyS,
  input  logic       resetS,
  output logic       settleLast,
  output logic       excLast,
  output logic       settled,
  output logic       armed
);

  localparam int SettleW = $clog2(SettleCycles + 1);
  localparam int ExcW = $clog2(ExcCycles + 1);
  localparam int HoldW = $clog2(PorHoldCycles + 1);
  localparam logic [SettleW-1:0] SettleEnd = SettleW'(SettleCycles - 1);
  localparam logic [ExcW-1:0] ExcEnd = ExcW'(ExcCycles - 1);
  localparam logic [HoldW-1:0] HoldEnd = HoldW'(PorHoldCycles);

  logic [SettleW-1:0] settleCnt;
  logic [ExcW-1:0] excCnt;
  logic [HoldW-1:0] holdCnt;

  assign settleLast = (settleCnt == SettleEnd);
  assign excLast = (excCnt == ExcEnd);

  // Oscillator settling counter and its done flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      settled <= 1'b0;
    end else if (strobe.settleClr) begin
      settleCnt <= '0;
      settled <= 1'b0;
    end else if (strobe.settleCount) begin
      if (settleLast) settled <= 1'b1;
      else            settleCnt <= settleCnt + 1'b1;
    end
  end

  // Exception-handling length counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excCnt <= '0;
    end else if (strobe.excClr) begin
      excCnt <= '0;
    end else if (strobe.excCount && !excLast) begin
      excCnt <= excCnt + 1'b1;
    end
  end

  // Power-up gate for standby entry: reset held long enough, then released.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (!standbyS) begin
        holdCnt <= '0;
      end else if (!resetS) begin
        if (holdCnt != HoldEnd) holdCnt <= holdCnt + 1'b1;
      end else begin
        if (holdCnt == HoldEnd) armed <= 1'b1;
        holdCnt <= '0;
      end
    end
  end

  a_r3_settle_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt <= SettleEnd);

  a_r3_settled_after_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settled) |-> $past(strobe.settleCount));

  a_r10_armed_sticky: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

endmodule

// File: rtl/hw_standby_ctrl.sv
module hw_standby_ctrl
  import hw_standby_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       standbyS,
  input  logic       resetS,
  input  logic       armed,
  input  logic       settleLast,
  input  logic       excLast,
  output seqStrobe_t strobe,
  output pwrState_t  state,
  output logic       excStart,
  output logic       violation
);

  pwrState_t nextState;
  logic standbyForce;

  assign standbyForce = !standbyS && !resetS && armed;

  always_comb begin
    nextState = state;
    if (standbyForce) begin
      nextState = ST_STANDBY;
    end else begin
      unique case (state)
        ST_STANDBY:      if (standbyS) nextState = ST_RESET_OSC;
        ST_RESET_OSC:    if (settleLast) nextState = ST_RESET_STABLE;
        ST_RESET_STABLE: if (resetS) nextState = ST_EXC;
        ST_EXC: begin
          if (!resetS)      nextState = ST_RESET_STABLE;
          else if (excLast) nextState = ST_RUN;
        end
        ST_RUN:          if (!resetS) nextState = ST_RESET_STABLE;
        default:         nextState = ST_RESET_OSC;
      endcase
    end
  end

  always_comb begin
    strobe.settleClr = (nextState != state) &&
                       (nextState == ST_RESET_OSC || nextState == ST_STANDBY);
    strobe.settleCount = (state == ST_RESET_OSC);
    strobe.excClr = (nextState == ST_EXC) && (state != ST_EXC);
    strobe.excCount = (state == ST_EXC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RESET_OSC;
      excStart <= 1'b0;
      violation <= 1'b0;
    end else begin
      state <= nextState;
      excStart <= strobe.excClr;
      if (nextState == ST_STANDBY)                 violation <= 1'b0;
      else if (state == ST_RESET_OSC && resetS)    violation <= 1'b1;
    end
  end

  a_r4_exc_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    excStart |=> !excStart);

  a_r4_exc_from_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_EXC) |-> $past(state) == ST_RESET_STABLE);

  a_r5_standby_needs_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_STANDBY) |-> $past(!resetS && !standbyS));

  a_r8_violation_clears_in_standby: assert property (@(posedge clk) disable iff (!rstN)
    $fell(violation) |-> state == ST_STANDBY);

  a_r10_unarmed_no_standby: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> state != ST_STANDBY);

  a_r11_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    state <= ST_RUN);

endmodule

// File: rtl/hw_standby_seq.sv
module hw_standby_seq
  import hw_standby_seq_pkg::*;
#(
  parameter int SettleCycles = 8192,
  parameter int ExcCycles = 4,
  parameter int PorHoldCycles = 16,
  parameter int SyncStages = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       standbyInN,
  input  logic       resetInN,
  output logic       oscEnable,
  output logic       settleDone,
  output logic [2:0] stateCode,
  output logic       excStart,
  output logic       runEnable,
  output logic       seqViolation
);

  logic [1:0] pinsSync;
  logic standbyS;
  logic resetS;
  logic armed;
  logic settleLast;
  logic excLast;
  seqStrobe_t strobe;
  pwrState_t state;

  // Bit 1: standby pin (idle high), bit 0: reset pin (asserted low at power-on).
  hw_standby_pin_sync #(
    .Width(2),
    .Stages(SyncStages),
    .ResetVal(2'b10)
  ) u_sync (
    .clk(clk),
    .rstN(porN),
    .din({standbyInN, resetInN}),
    .dout(pinsSync)
  );

  assign standbyS = pinsSync[1];
  assign resetS = pinsSync[0];

  hw_standby_ctrl u_ctrl (
    .clk(clk),
    .rstN(porN),
    .standbyS(standbyS),
    .resetS(resetS),
    .armed(armed),
    .settleLast(settleLast),
    .excLast(excLast),
    .strobe(strobe),
    .state(state),
    .excStart(excStart),
    .violation(seqViolation)
  );

  hw_standby_datapath #(
    .SettleCycles(SettleCycles),
    .ExcCycles(ExcCycles),
    .PorHoldCycles(PorHoldCycles)
  ) u_datapath (
    .clk(clk),
    .rstN(porN),
    .strobe(strobe),
    .standbyS(standbyS),
    .resetS(resetS),
    .settleLast(settleLast),
    .excLast(excLast),
    .settled(settleDone),
    .armed(armed)
  );

  assign stateCode = state;
  assign oscEnable = (state != ST_STANDBY);
  assign runEnable = (state == ST_RUN);

  a_r3_stable_implies_settled: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RESET_STABLE) |-> settleDone);

  a_r9_no_resettle_from_run: assert property (@(posedge clk) disable iff (!porN)
    ($past(state) == ST_RUN && state == ST_RESET_STABLE) |-> settleDone);

endmodule

// File: tb/hw_standby_seq_bench.sv
module hw_standby_seq_bench;

  localparam int Settle = 20;
  localparam int Exc = 3;
  localparam int Hold = 5;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic standbyInN = 1'b1;
  logic resetInN = 1'b0;
  logic oscEnable, settleDone, excStart, runEnable, seqViolation;
  logic [2:0] stateCode;

  int checkCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  hw_standby_seq #(
    .SettleCycles(Settle),
    .ExcCycles(Exc),
    .PorHoldCycles(Hold),
    .SyncStages(2)
  ) u_hw_standby_seq (
    .clk(clk),
    .porN(porN),
    .standbyInN(standbyInN),
    .resetInN(resetInN),
    .oscEnable(oscEnable),
    .settleDone(settleDone),
    .stateCode(stateCode),
    .excStart(excStart),
    .runEnable(runEnable),
    .seqViolation(seqViolation)
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countWhile(input int code, output int n);
    n = 0;
    while (stateCode == 3'(code)) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitState(input int code);
    while (stateCode != 3'(code)) @(negedge clk);
  endtask

  // Starting from run, enter standby, leave it, and release reset at offset k.
  task automatic releaseAt(input int k);
    int n;
    resetInN = 1'b0;
    waitCycles(5);
    standbyInN = 1'b0;
    waitCycles(5);
    chk("R5 standby reached before sweep", stateCode, 0);
    chk("R8 violation cleared by standby", seqViolation, 0);
    standbyInN = 1'b1;
    for (int i = 0; i < k; i++) @(negedge clk);
    resetInN = 1'b1;
    waitState(4);
    chk($sformatf("R8 violation for release offset %0d", k), seqViolation, (k <= Settle) ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int n;
    // R2: reset state
    waitCycles(3);
    chk("R2 state in power-on", stateCode, 1);
    chk("R2 osc enable in power-on", oscEnable, 1);
    chk("R2 settleDone in power-on", settleDone, 0);
    chk("R2 runEnable in power-on", runEnable, 0);
    chk("R2 excStart in power-on", excStart, 0);
    chk("R2 violation in power-on", seqViolation, 0);

    // R3: first settling period from power-on release
    porN = 1'b1;
    countWhile(1, n);
    chk("R3 settle length after power-on", n, Settle);
    chk("R3 settled state code", stateCode, 2);
    chk("R3 settleDone with state 2", settleDone, 1);

    // R1 and R4: release reset
    resetInN = 1'b1;
    countWhile(2, n);
    chk("R1 pin to state latency", n, 3);
    chk("R4 exception state code", stateCode, 3);
    chk("R4 excStart first cycle", excStart, 1);
    @(negedge clk);
    chk("R4 excStart single cycle", excStart, 0);
    countWhile(3, n);
    chk("R4 exception length", n + 1, Exc);
    chk("R4 run state code", stateCode, 4);
    chk("R4 runEnable in run", runEnable, 1);
    chk("R8 no violation after proper release", seqViolation, 0);

    // R6: standby low with reset high is ignored
    standbyInN = 1'b0;
    waitCycles(8);
    chk("R6 state unchanged", stateCode, 4);
    chk("R6 runEnable unchanged", runEnable, 1);
    chk("R6 oscEnable unchanged", oscEnable, 1);
    standbyInN = 1'b1;
    waitCycles(4);

    // R9: reset low in run goes to settled reset without re-settling
    resetInN = 1'b0;
    waitCycles(3);
    chk("R9 run to state 2", stateCode, 2);
    chk("R9 settleDone kept", settleDone, 1);
    chk("R9 runEnable off", runEnable, 0);

    // R5: standby entry
    standbyInN = 1'b0;
    waitCycles(3);
    chk("R5 standby state", stateCode, 0);
    chk("R5 osc off", oscEnable, 0);
    chk("R5 settleDone off", settleDone, 0);
    chk("R5 run off", runEnable, 0);

    // R7 and R3: leave standby, settling restarts
    standbyInN = 1'b1;
    countWhile(0, n);
    chk("R7 standby exit latency", n, 3);
    chk("R7 state after exit", stateCode, 1);
    countWhile(1, n);
    chk("R3 settle length after standby", n, Settle);
    resetInN = 1'b1;
    waitState(4);

    // R8: early release, swept across the settling boundary
    releaseAt(2);
    chk("R8 run still reached after early release", runEnable, 1);
    for (int k = Settle - 3; k <= Settle + 2; k++) releaseAt(k);

    // R10: power-up gate
    porN = 1'b0;
    resetInN = 1'b1;
    standbyInN = 1'b1;
    waitCycles(3);
    porN = 1'b1;
    waitCycles(4);
    resetInN = 1'b0;
    waitCycles(2);
    resetInN = 1'b1;
    waitCycles(5);
    resetInN = 1'b0;
    standbyInN = 1'b0;
    waitCycles(8);
    chk("R10 short hold keeps standby blocked", (stateCode != 0) ? 1 : 0, 1);
    chk("R10 osc stays on while blocked", oscEnable, 1);
    standbyInN = 1'b1;
    waitCycles(Hold + 5);
    resetInN = 1'b1;
    waitCycles(5);
    resetInN = 1'b0;
    waitCycles(5);
    standbyInN = 1'b0;
    waitCycles(5);
    chk("R10 standby allowed once armed", stateCode, 0);
    chk("R11 state code never above 4", (stateCode <= 3'd4) ? 1 : 0, 1);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule